// File: doc/BRIEF.md
# Burst Prefetch Buffer Queue

This block is the data store behind one prefetch engine. It holds a small ring of blocks, each large enough for one read burst. The controller claims a block as soon as it sends a prefetch request to memory, long before any data comes back. Beats returning from memory then fill the claimed blocks in the order they were claimed. The initiator side drains finished blocks one beat at a time, oldest first.

Three status outputs feed the controller. `count_o` is the number of finished blocks waiting to be read. `outstanding_o` shows that some claimed block still lacks data, which is the condition the controller waits on before it wipes the queue. `afull_o` compares the number of claimed blocks with a threshold set at run time. A single-cycle flush drops every block, both pointers and any burst that is only partly filled.

Top module: `burst_prefetch_queue`

## Requirements
- R1: After reset the queue is empty: `rsv_ready_o`=1, `rd_valid_o`=0, `wr_ready_o`=0, `count_o`=0, `outstanding_o`=0.
- R2: A reserve is accepted while fewer than NUM_BLOCKS blocks are allocated. When all blocks are allocated, `rsv_ready_o` is low and a reserve request has no effect. Releasing a block by reading it out makes room again.
- R3: Write beats fill the oldest reserved, unfilled block in reservation order. `wr_ready_o` is low while no such block exists.
- R4: `wr_len_i` uses the "beats minus one" encoding. A block becomes readable only after beat number `wr_len_i`+1 has been written, and `rd_valid_o` stays low before then.
- R5: Reads return the head block's beats in the order they were written. `rd_last_o` is high on the final beat only. Blocks leave in reservation order.
- R6: A `wr_len_i` above MAX_BEATS-1 is clamped, so the block completes after MAX_BEATS beats.
- R7: `count_o` equals the number of completely written blocks that have not yet been fully read.
- R8: `outstanding_o` is high exactly when at least one reserved block is not yet completely written.
- R9: `afull_o` is high when the number of allocated blocks (reserved, filled or partly read) is at least `afull_thr_i`.
- R10: `flush_i` empties the queue in one cycle. Reserve, write and read requests in the flush cycle are discarded. Beat offsets restart, so the next burst lands at beat 0 of a new block.
- R11: While `rd_valid_o` is high and `rd_ready_i` is low, the presented beat, its data and `rd_last_o` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rsv_valid_i | input | 1 | Reserve a block for a new prefetch request |
| rsv_ready_o | output | 1 | A free block is available |
| wr_valid_i | input | 1 | Beat from memory is valid |
| wr_ready_o | output | 1 | A reserved block is waiting for data |
| wr_len_i | input | LEN_W (8) | Burst length of the incoming burst, beats minus one |
| wr_data_i | input | DATA_W (256) | Incoming beat data |
| rd_valid_o | output | 1 | Head block beat available |
| rd_ready_i | input | 1 | Initiator accepts the beat |
| rd_data_o | output | DATA_W (256) | Outgoing beat data |
| rd_last_o | output | 1 | Final beat of the head block |
| flush_i | input | 1 | Drop all blocks and pointers |
| afull_thr_i | input | CNT_W (3) | Almost-full threshold in blocks |
| afull_o | output | 1 | Allocated blocks at or above threshold |
| count_o | output | CNT_W (3) | Filled blocks held |
| outstanding_o | output | 1 | Some reserved block lacks data |

## Verification
The bench watches the head block while its burst is only partly written. A design that exposed it early would raise `rd_valid_o` before the final beat. The bench also makes a reserve request against a full queue. If that request were accepted, a fifth pending block would keep `wr_ready_o` high after all four blocks are filled. A flush lands while a burst is half written and while write and reserve requests are active in the same cycle. A design that let the beat offset survive the flush would place the next burst's first beat at the wrong offset. An oversized burst length checks that the clamp ends the block after its capacity, so the write offset cannot run past the end of the block.

// File: rtl/bq_pkg.sv
package bq_pkg;
   // Per-cycle events that move the queue pointers and counters.
   typedef struct packed {
      logic rsv;      // block allocated at tail
      logic wr_done;  // final beat of a burst written
      logic rd_done;  // final beat of head block consumed
      logic flush;    // wipe everything
   } bq_evt_t;
endpackage

// File: rtl/bq_ring_ctrl.sv
module bq_ring_ctrl
   import bq_pkg::*;
#(
   parameter int NUM_BLOCKS = 4,
   parameter int PTR_W      = $clog2(NUM_BLOCKS),
   parameter int CNT_W      = $clog2(NUM_BLOCKS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  bq_evt_t          evt_i,
   output logic [PTR_W-1:0] head_o,
   output logic [PTR_W-1:0] fill_o,
   output logic [PTR_W-1:0] tail_o,
   output logic [CNT_W-1:0] occ_o,
   output logic [CNT_W-1:0] pend_o
);
   logic [PTR_W-1:0] head_q, fill_q, tail_q;
   logic [CNT_W-1:0] occ_q, pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q <= '0;
         fill_q <= '0;
         tail_q <= '0;
         occ_q  <= '0;
         pend_q <= '0;
      end else if (evt_i.flush) begin
         head_q <= '0;
         fill_q <= '0;
         tail_q <= '0;
         occ_q  <= '0;
         pend_q <= '0;
      end else begin
         if (evt_i.rsv)     tail_q <= tail_q + 1'b1;
         if (evt_i.wr_done) fill_q <= fill_q + 1'b1;
         if (evt_i.rd_done) head_q <= head_q + 1'b1;
         occ_q  <= occ_q + CNT_W'(evt_i.rsv) - CNT_W'(evt_i.rd_done);
         pend_q <= pend_q + CNT_W'(evt_i.rsv) - CNT_W'(evt_i.wr_done);
      end
   end

   assign head_o = head_q;
   assign fill_o = fill_q;
   assign tail_o = tail_q;
   assign occ_o  = occ_q;
   assign pend_o = pend_q;
endmodule

// File: rtl/bq_block_tags.sv
module bq_block_tags #(
   parameter int NUM_BLOCKS = 4,
   parameter int PTR_W      = $clog2(NUM_BLOCKS),
   parameter int OFF_W      = 2
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              flush_i,
   input  logic                              set_i,
   input  logic [PTR_W-1:0]                  set_idx_i,
   input  logic [OFF_W-1:0]                  set_len_i,
   input  logic                              clr_i,
   input  logic [PTR_W-1:0]                  clr_idx_i,
   output logic [NUM_BLOCKS-1:0]             done_o,
   output logic [NUM_BLOCKS-1:0][OFF_W-1:0]  len_o
);
   for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_tag
      logic             done_q;
      logic [OFF_W-1:0] len_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            done_q <= 1'b0;
            len_q  <= '0;
         end else if (flush_i) begin
            done_q <= 1'b0;
            len_q  <= '0;
         end else if (set_i && (set_idx_i == PTR_W'(b))) begin
            done_q <= 1'b1;
            len_q  <= set_len_i;
         end else if (clr_i && (clr_idx_i == PTR_W'(b))) begin
            done_q <= 1'b0;
         end
      end

      assign done_o[b] = done_q;
      assign len_o[b]  = len_q;
   end
endmodule

// File: rtl/bq_beat_ram.sv
module bq_beat_ram #(
   parameter int DATA_W     = 256,
   parameter int NUM_BLOCKS = 4,
   parameter int MAX_BEATS  = 4,
   parameter int PTR_W      = $clog2(NUM_BLOCKS),
   parameter int OFF_W      = $clog2(MAX_BEATS)
) (
   input  logic              clk,
   input  logic              wr_en_i,
   input  logic [PTR_W-1:0]  wr_blk_i,
   input  logic [OFF_W-1:0]  wr_off_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [PTR_W-1:0]  rd_blk_i,
   input  logic [OFF_W-1:0]  rd_off_i,
   output logic [DATA_W-1:0] rd_data_o
);
   localparam int ROWS  = NUM_BLOCKS * MAX_BEATS;
   localparam int ROW_W = PTR_W + OFF_W;

   logic [DATA_W-1:0] row_q [ROWS];
   logic [ROW_W-1:0]  wr_row;

   assign wr_row = {wr_blk_i, wr_off_i};

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      always_ff @(posedge clk) begin
         if (wr_en_i && (wr_row == ROW_W'(r))) row_q[r] <= wr_data_i;
      end
   end

   assign rd_data_o = row_q[{rd_blk_i, rd_off_i}];
endmodule

// File: rtl/burst_prefetch_queue.sv
module burst_prefetch_queue
   import bq_pkg::*;
#(
   parameter int DATA_W     = 256,
   parameter int LEN_W      = 8,
   parameter int NUM_BLOCKS = 4,
   parameter int MAX_BEATS  = 4,
   parameter int PTR_W      = $clog2(NUM_BLOCKS),
   parameter int CNT_W      = $clog2(NUM_BLOCKS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rsv_valid_i,
   output logic              rsv_ready_o,
   input  logic              wr_valid_i,
   output logic              wr_ready_o,
   input  logic [LEN_W-1:0]  wr_len_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic              rd_valid_o,
   input  logic              rd_ready_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              rd_last_o,
   input  logic              flush_i,
   input  logic [CNT_W-1:0]  afull_thr_i,
   output logic              afull_o,
   output logic [CNT_W-1:0]  count_o,
   output logic              outstanding_o
);
   localparam int OFF_W = $clog2(MAX_BEATS);
   localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(MAX_BEATS - 1);

   if (NUM_BLOCKS < 2 || (1 << PTR_W) != NUM_BLOCKS) begin : g_chk_blocks
      $error("NUM_BLOCKS must be a power of two, at least 2");
   end
   if (MAX_BEATS < 2 || (1 << OFF_W) != MAX_BEATS) begin : g_chk_beats
      $error("MAX_BEATS must be a power of two, at least 2");
   end
   if (LEN_W < OFF_W) begin : g_chk_len
      $error("LEN_W too narrow for MAX_BEATS");
   end

   bq_evt_t                             evt;
   logic [PTR_W-1:0]                    head, fill, tail;
   logic [CNT_W-1:0]                    occ, pend;
   logic [NUM_BLOCKS-1:0]               blk_done;
   logic [NUM_BLOCKS-1:0][OFF_W-1:0]    blk_len;
   logic [OFF_W-1:0]                    wr_off_q, rd_off_q, eff_len;
   logic                                rsv_fire, wr_fire, rd_fire;

   // Clamp the burst length to block capacity.
   assign eff_len = (wr_len_i > LEN_CAP) ? OFF_W'(MAX_BEATS - 1) : wr_len_i[OFF_W-1:0];

   assign rsv_ready_o = (occ != CNT_W'(NUM_BLOCKS));
   assign wr_ready_o  = (pend != '0);
   assign rd_valid_o  = blk_done[head];
   assign rd_last_o   = rd_valid_o && (rd_off_q == blk_len[head]);

   assign rsv_fire = rsv_valid_i && rsv_ready_o && !flush_i;
   assign wr_fire  = wr_valid_i && wr_ready_o && !flush_i;
   assign rd_fire  = rd_valid_o && rd_ready_i && !flush_i;

   assign evt.rsv     = rsv_fire;
   assign evt.wr_done = wr_fire && (wr_off_q == eff_len);
   assign evt.rd_done = rd_fire && rd_last_o;
   assign evt.flush   = flush_i;

   // Burst offset pointers for the fill side and the drain side.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_off_q <= '0;
         rd_off_q <= '0;
      end else if (flush_i) begin
         wr_off_q <= '0;
         rd_off_q <= '0;
      end else begin
         if (wr_fire) wr_off_q <= evt.wr_done ? '0 : wr_off_q + 1'b1;
         if (rd_fire) rd_off_q <= evt.rd_done ? '0 : rd_off_q + 1'b1;
      end
   end

   bq_ring_ctrl #(
      .NUM_BLOCKS (NUM_BLOCKS),
      .PTR_W      (PTR_W),
      .CNT_W      (CNT_W)
   ) ring_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt_i  (evt),
      .head_o (head),
      .fill_o (fill),
      .tail_o (tail),
      .occ_o  (occ),
      .pend_o (pend)
   );

   bq_block_tags #(
      .NUM_BLOCKS (NUM_BLOCKS),
      .PTR_W      (PTR_W),
      .OFF_W      (OFF_W)
   ) tags_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush_i   (flush_i),
      .set_i     (evt.wr_done),
      .set_idx_i (fill),
      .set_len_i (eff_len),
      .clr_i     (evt.rd_done),
      .clr_idx_i (head),
      .done_o    (blk_done),
      .len_o     (blk_len)
   );

   bq_beat_ram #(
      .DATA_W     (DATA_W),
      .NUM_BLOCKS (NUM_BLOCKS),
      .MAX_BEATS  (MAX_BEATS),
      .PTR_W      (PTR_W),
      .OFF_W      (OFF_W)
   ) ram_i (
      .clk       (clk),
      .wr_en_i   (wr_fire),
      .wr_blk_i  (fill),
      .wr_off_i  (wr_off_q),
      .wr_data_i (wr_data_i),
      .rd_blk_i  (head),
      .rd_off_i  (rd_off_q),
      .rd_data_o (rd_data_o)
   );

   assign count_o       = occ - pend;
   assign outstanding_o = (pend != '0);
   assign afull_o       = (occ >= afull_thr_i);

   logic unused_tail;
   assign unused_tail = ^tail;
endmodule

// File: rtl/bq_queue_chk.sv
module bq_queue_chk #(
   parameter int DATA_W     = 256,
   parameter int NUM_BLOCKS = 4,
   parameter int CNT_W      = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rsv_ready_o,
   input logic              wr_valid_i,
   input logic              rd_valid_o,
   input logic              rd_ready_i,
   input logic [DATA_W-1:0] rd_data_o,
   input logic              rd_last_o,
   input logic              flush_i,
   input logic [CNT_W-1:0]  afull_thr_i,
   input logic              afull_o,
   input logic [CNT_W-1:0]  count_o,
   input logic              outstanding_o
);
   a_r2_full_stays_refused: assert property (@(posedge clk) disable iff (!rst_n)
      (!rsv_ready_o && !(rd_valid_o && rd_ready_i) && !flush_i) |=> !rsv_ready_o);

   a_r4_valid_implies_filled: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid_o |-> (count_o != '0));

   a_r5_last_releases_block: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid_o && rd_ready_i && rd_last_o && !flush_i && !wr_valid_i)
      |=> (count_o == $past(count_o) - 1'b1));

   a_r8_pending_persists: assert property (@(posedge clk) disable iff (!rst_n)
      (outstanding_o && !flush_i && !wr_valid_i) |=> outstanding_o);

   a_r9_full_is_afull: assert property (@(posedge clk) disable iff (!rst_n)
      ((count_o == CNT_W'(NUM_BLOCKS)) && (afull_thr_i <= CNT_W'(NUM_BLOCKS))) |-> afull_o);

   a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> (!rd_valid_o && !outstanding_o && (count_o == '0) && rsv_ready_o));

   a_r11_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid_o && !rd_ready_i && !flush_i)
      |=> (rd_valid_o && $stable(rd_data_o) && $stable(rd_last_o)));
endmodule

bind burst_prefetch_queue bq_queue_chk #(
   .DATA_W     (DATA_W),
   .NUM_BLOCKS (NUM_BLOCKS),
   .CNT_W      (CNT_W)
) chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .rsv_ready_o   (rsv_ready_o),
   .wr_valid_i    (wr_valid_i),
   .rd_valid_o    (rd_valid_o),
   .rd_ready_i    (rd_ready_i),
   .rd_data_o     (rd_data_o),
   .rd_last_o     (rd_last_o),
   .flush_i       (flush_i),
   .afull_thr_i   (afull_thr_i),
   .afull_o       (afull_o),
   .count_o       (count_o),
   .outstanding_o (outstanding_o)
);

// File: tb/burst_prefetch_queue_tb_top.sv
module burst_prefetch_queue_tb_top;
   localparam int DATA_W = 256;
   localparam int LEN_W  = 8;
   localparam int NB     = 4;
   localparam int MB     = 4;
   localparam int CNT_W  = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              rsv_valid_i = 1'b0;
   logic              rsv_ready_o;
   logic              wr_valid_i = 1'b0;
   logic              wr_ready_o;
   logic [LEN_W-1:0]  wr_len_i = '0;
   logic [DATA_W-1:0] wr_data_i = '0;
   logic              rd_valid_o;
   logic              rd_ready_i = 1'b0;
   logic [DATA_W-1:0] rd_data_o;
   logic              rd_last_o;
   logic              flush_i = 1'b0;
   logic [CNT_W-1:0]  afull_thr_i = 3'd3;
   logic              afull_o;
   logic [CNT_W-1:0]  count_o;
   logic              outstanding_o;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   burst_prefetch_queue #(
      .DATA_W (DATA_W), .LEN_W (LEN_W), .NUM_BLOCKS (NB), .MAX_BEATS (MB)
   ) dut_i (
      .clk (clk), .rst_n (rst_n),
      .rsv_valid_i (rsv_valid_i), .rsv_ready_o (rsv_ready_o),
      .wr_valid_i (wr_valid_i), .wr_ready_o (wr_ready_o),
      .wr_len_i (wr_len_i), .wr_data_i (wr_data_i),
      .rd_valid_o (rd_valid_o), .rd_ready_i (rd_ready_i),
      .rd_data_o (rd_data_o), .rd_last_o (rd_last_o),
      .flush_i (flush_i), .afull_thr_i (afull_thr_i), .afull_o (afull_o),
      .count_o (count_o), .outstanding_o (outstanding_o)
   );

   function automatic logic [DATA_W-1:0] pat(input logic [63:0] v);
      return {4{v}};
   endfunction

   task automatic check(input bit ok, input string req, input logic [DATA_W-1:0] act,
                        input logic [DATA_W-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic reserve_one(input string req);
      check(rsv_ready_o == 1'b1, req, DATA_W'(rsv_ready_o), 1);
      rsv_valid_i = 1'b1;
      step();
      rsv_valid_i = 1'b0;
   endtask

   task automatic write_beats(input logic [LEN_W-1:0] len, input logic [63:0] base,
                              input int nbeats);
      for (int i = 0; i < nbeats; i++) begin
         wr_valid_i = 1'b1;
         wr_len_i   = len;
         wr_data_i  = pat(base + 64'(i));
         step();
      end
      wr_valid_i = 1'b0;
   endtask

   task automatic read_block(input logic [63:0] base, input int nbeats, input string req);
      for (int i = 0; i < nbeats; i++) begin
         check(rd_valid_o == 1'b1, req, DATA_W'(rd_valid_o), 1);
         check(rd_data_o == pat(base + 64'(i)), req, rd_data_o, pat(base + 64'(i)));
         check(rd_last_o == (i == nbeats - 1), req, DATA_W'(rd_last_o),
               DATA_W'(i == nbeats - 1));
         rd_ready_i = 1'b1;
         step();
         rd_ready_i = 1'b0;
      end
   endtask

   task automatic do_flush();
      flush_i = 1'b1;
      step();
      flush_i = 1'b0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      step();
      rst_n = 1'b1;
      step();
      check(rsv_ready_o == 1'b1, "R1", DATA_W'(rsv_ready_o), 1);
      check(rd_valid_o == 1'b0, "R1", DATA_W'(rd_valid_o), 0);
      check(wr_ready_o == 1'b0, "R1", DATA_W'(wr_ready_o), 0);
      check(count_o == 0, "R1", DATA_W'(count_o), 0);
      check(outstanding_o == 1'b0, "R1", DATA_W'(outstanding_o), 0);
   endtask

   task automatic t_basic();
      reserve_one("R2");
      check(outstanding_o == 1'b1, "R8", DATA_W'(outstanding_o), 1);
      check(wr_ready_o == 1'b1, "R3", DATA_W'(wr_ready_o), 1);
      write_beats(8'd2, 64'h100, 2);
      check(rd_valid_o == 1'b0, "R4", DATA_W'(rd_valid_o), 0);
      check(count_o == 0, "R7", DATA_W'(count_o), 0);
      write_beats(8'd2, 64'h102, 1);
      check(count_o == 1, "R7", DATA_W'(count_o), 1);
      check(outstanding_o == 1'b0, "R8", DATA_W'(outstanding_o), 0);
      check(wr_ready_o == 1'b0, "R3", DATA_W'(wr_ready_o), 0);
      read_block(64'h100, 3, "R5");
      check(count_o == 0, "R7", DATA_W'(count_o), 0);
      check(rd_valid_o == 1'b0, "R5", DATA_W'(rd_valid_o), 0);
   endtask

   task automatic t_order();
      afull_thr_i = 3'd3;
      reserve_one("R2");
      reserve_one("R2");
      check(afull_o == 1'b0, "R9", DATA_W'(afull_o), 0);
      reserve_one("R2");
      check(afull_o == 1'b1, "R9", DATA_W'(afull_o), 1);
      write_beats(8'd0, 64'h200, 1);
      write_beats(8'd1, 64'h300, 2);
      write_beats(8'd3, 64'h400, 4);
      check(count_o == 3, "R7", DATA_W'(count_o), 3);
      read_block(64'h200, 1, "R5");
      check(afull_o == 1'b0, "R9", DATA_W'(afull_o), 0);
      read_block(64'h300, 2, "R5");
      read_block(64'h400, 4, "R3");
   endtask

   task automatic t_full();
      for (int k = 0; k < NB; k++) reserve_one("R2");
      check(rsv_ready_o == 1'b0, "R2", DATA_W'(rsv_ready_o), 0);
      rsv_valid_i = 1'b1;
      step();
      rsv_valid_i = 1'b0;
      for (int k = 0; k < NB; k++) write_beats(8'd0, 64'h500 + 64'(k), 1);
      check(wr_ready_o == 1'b0, "R2", DATA_W'(wr_ready_o), 0);
      check(count_o == NB, "R7", DATA_W'(count_o), NB);
      read_block(64'h500, 1, "R5");
      check(rsv_ready_o == 1'b1, "R2", DATA_W'(rsv_ready_o), 1);
      do_flush();
   endtask

   task automatic t_clamp();
      reserve_one("R6");
      write_beats(8'd9, 64'h600, 3);
      check(rd_valid_o == 1'b0, "R6", DATA_W'(rd_valid_o), 0);
      write_beats(8'd9, 64'h603, 1);
      check(count_o == 1, "R6", DATA_W'(count_o), 1);
      check(wr_ready_o == 1'b0, "R6", DATA_W'(wr_ready_o), 0);
      read_block(64'h600, 4, "R6");
   endtask

   task automatic t_flush();
      reserve_one("R10");
      reserve_one("R10");
      write_beats(8'd1, 64'h700, 1);
      flush_i     = 1'b1;
      wr_valid_i  = 1'b1;
      rsv_valid_i = 1'b1;
      wr_data_i   = pat(64'h7ff);
      step();
      flush_i = 1'b0; wr_valid_i = 1'b0; rsv_valid_i = 1'b0;
      check(outstanding_o == 1'b0, "R10", DATA_W'(outstanding_o), 0);
      check(count_o == 0, "R10", DATA_W'(count_o), 0);
      check(wr_ready_o == 1'b0, "R10", DATA_W'(wr_ready_o), 0);
      check(rd_valid_o == 1'b0, "R10", DATA_W'(rd_valid_o), 0);
      check(rsv_ready_o == 1'b1, "R10", DATA_W'(rsv_ready_o), 1);
      reserve_one("R10");
      write_beats(8'd1, 64'h800, 2);
      read_block(64'h800, 2, "R10");
   endtask

   task automatic t_hold();
      reserve_one("R11");
      write_beats(8'd1, 64'h900, 2);
      for (int c = 0; c < 3; c++) begin
         check(rd_valid_o == 1'b1, "R11", DATA_W'(rd_valid_o), 1);
         check(rd_data_o == pat(64'h900), "R11", rd_data_o, pat(64'h900));
         check(rd_last_o == 1'b0, "R11", DATA_W'(rd_last_o), 0);
         step();
      end
      read_block(64'h900, 2, "R11");
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_basic();
      t_order();
      t_full();
      t_clamp();
      t_flush();
      t_hold();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule